// File: doc/BRIEF.md
# Bus and Pin Wake-up Detector

This block watches two slow digital indications while a transceiver sits in a low-power mode. The first is the output of a low-power bus activity comparator (1 = bus dominant). The second is the level of a local wake pin. It raises a sticky wake-up event when it sees either of two things. One is a remote wake pattern on the bus. The other is a debounced level change on the pin. It also tells the mode controller whether that event came from the pin.

The remote pattern is two dominant phases, each held for a minimum number of cycles and each followed by a recessive phase that is also held for a minimum number of cycles. A phase that ends early throws away the partial pattern. The pin side accepts a change in either direction once the new level has held for the debounce time. The settled level also sets the direction of the pin's bias current. The mode controller arms detection by asserting `lowpwr_mode` whenever the transceiver is in standby, go-to-sleep or sleep. It blocks detection with `inhibit` during the waiting period after a supply undervoltage. It clears the event with `clr`.

Top module: `wake_detector`

## Requirements
- R1: A wake-up event is raised only in a cycle where `lowpwr_mode`=1 and `inhibit`=0. Leaving that condition does not clear an event that is already raised.
- R2: Both inputs pass through a two-flop synchroniser, and all durations are counted in synchronised samples. A remote wake-up needs four phases in order: dominant for at least DOM_MIN samples, recessive for at least REC_MIN samples, dominant for at least DOM_MIN samples, and recessive again. `wake_evt` rises on the REC_MIN-th sample of that last recessive phase. A remote wake-up leaves `wake_local` unchanged.
- R3: A dominant phase shorter than DOM_MIN restarts the remote search. A recessive phase shorter than REC_MIN after a good dominant phase also restarts it, and the dominant phase that ends it counts as a new first dominant phase.
- R4: `wake_evt` and `wake_local` hold until `clr`=1. A new detection in the same cycle as `clr` wins, and the event is still raised.
- R5: A pin level that differs from the settled level for DEB_CYC consecutive synchronised samples becomes the new settled level. When armed, this raises both `wake_evt` and `wake_local`. Rising and falling changes are treated the same way.
- R6: `bias_up` equals the settled pin level (1 = pull-up, 0 = pull-down) at all times, armed or not. A change that lasts fewer than DEB_CYC samples has no effect on it.
- R7: Dropping `inhibit` low or leaving low-power mode discards a partly seen remote pattern. A pin change that settles while not armed updates `bias_up` but never raises an event, either then or later.
- R8: After reset, `wake_evt`=0, `wake_local`=0 and `bias_up`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lowpwr_mode | input | 1 | 1 while in standby, go-to-sleep or sleep |
| inhibit | input | 1 | 1 blocks detection (undervoltage waiting period) |
| clr | input | 1 | Clears the wake-up flags |
| bus_dom | input | 1 | Asynchronous bus activity, 1 = dominant |
| wake_pin | input | 1 | Asynchronous wake pin level |
| wake_evt | output | 1 | Sticky wake-up event |
| wake_local | output | 1 | Sticky flag: the event came from the pin |
| bias_up | output | 1 | Pin bias direction, 1 = pull-up, 0 = pull-down |

## Verification
The hardest situations to reach are the ones where the remote search must restart in the middle of a pattern. Examples are a recessive gap one sample too short after a good dominant phase, or `inhibit` rising between the first and second pair. There the following dominant phase has to be counted as a first phase and not a second. The stimulus drives exact run lengths on `bus_dom` at the minimum and one below it. It then appends a single extra pair so that a premature or missing restart shows up as a wrong event.

The pin side is driven with glitches shorter than the debounce time, with changes settled while disarmed, and with `clr` held high through a detection. A behavioural reference model runs alongside and follows every cycle of these sequences.

// File: rtl/wk_pkg.sv
`timescale 1ns/1ps
package wk_pkg;
  typedef enum logic [1:0] {
    RW_IDLE = 2'd0,
    RW_DOM  = 2'd1,
    RW_REC  = 2'd2
  } rw_state_e;
endpackage

// File: rtl/wk_sync.sv
`timescale 1ns/1ps
module wk_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta, stab;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta <= 1'b0;
        stab <= 1'b0;
      end else begin
        meta <= d[i];
        stab <= meta;
      end
    end
    assign q[i] = stab;
  end
endmodule

// File: rtl/wk_remote.sv
`timescale 1ns/1ps
module wk_remote
  import wk_pkg::*;
#(
  parameter int DOM_MIN = 8,
  parameter int REC_MIN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic dom,
  output logic hit
);
  localparam int MAXC = (DOM_MIN > REC_MIN) ? DOM_MIN : REC_MIN;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] DOM_LIM  = CW'(DOM_MIN);
  localparam logic [CW-1:0] REC_LIM  = CW'(REC_MIN);
  localparam logic [CW-1:0] REC_LAST = CW'(REC_MIN - 1);
  localparam logic [CW-1:0] ONE      = CW'(1);

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] c, input logic [CW-1:0] lim);
    return (c >= lim) ? c : c + 1'b1;
  endfunction

  rw_state_e st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic second, second_n;   // 1: current pair is the second one
  logic dom_short;          // dominant ended below its minimum
  logic rec_done;           // last recessive sample of the second pair

  assign dom_short = (st == RW_DOM) && !dom && (cnt < DOM_LIM);
  assign rec_done  = (st == RW_REC) && !dom && second && (cnt == REC_LAST);

  always_comb begin
    st_n = st;
    cnt_n = cnt;
    second_n = second;
    hit = 1'b0;
    if (!armed) begin
      st_n = RW_IDLE; cnt_n = '0; second_n = 1'b0;
    end else begin
      case (st)
        RW_IDLE: if (dom) begin
          st_n = RW_DOM; cnt_n = ONE; second_n = 1'b0;
        end
        RW_DOM: begin
          if (dom) cnt_n = sat_inc(cnt, DOM_LIM);
          else if (cnt >= DOM_LIM) begin st_n = RW_REC; cnt_n = ONE; end
          else begin st_n = RW_IDLE; cnt_n = '0; second_n = 1'b0; end
        end
        RW_REC: begin
          if (!dom) begin
            if (rec_done) begin
              hit = 1'b1; st_n = RW_IDLE; cnt_n = '0; second_n = 1'b0;
            end else cnt_n = sat_inc(cnt, REC_LIM);
          end else begin
            st_n = RW_DOM; cnt_n = ONE; second_n = (cnt >= REC_LIM);
          end
        end
        default: begin st_n = RW_IDLE; cnt_n = '0; second_n = 1'b0; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RW_IDLE; cnt <= '0; second <= 1'b0;
    end else begin
      st <= st_n; cnt <= cnt_n; second <= second_n;
    end
  end

  assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && dom_short) |=> (st == RW_IDLE && !second))
    else $error("short dominant did not restart");
  assert_hit_rec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (!dom && $past(!dom)))
    else $error("remote hit outside a recessive run");
  assert_disarm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> (st == RW_IDLE))
    else $error("pattern survived disarm");
endmodule

// File: rtl/wk_local.sv
`timescale 1ns/1ps
module wk_local #(
  parameter int DEB_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic pin,
  output logic level,
  output logic hit
);
  localparam int CW = $clog2(DEB_CYC + 1);
  localparam logic [CW-1:0] DEB_LAST = CW'(DEB_CYC - 1);

  logic          lvl_q;
  logic [CW-1:0] dcnt;
  logic          differs, settle;

  assign differs = (pin != lvl_q);
  assign settle  = differs && (dcnt == DEB_LAST);
  assign hit     = settle && armed;
  assign level   = lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      dcnt  <= '0;
    end else if (settle) begin
      lvl_q <= pin;
      dcnt  <= '0;
    end else if (differs) begin
      dcnt <= dcnt + 1'b1;
    end else begin
      dcnt <= '0;
    end
  end

  assert_glitch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !differs |=> $stable(lvl_q))
    else $error("bias moved without a differing sample");
  assert_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_q) |-> (lvl_q == $past(pin)))
    else $error("bias took a level the pin did not have");
endmodule

// File: rtl/wake_detector.sv
`timescale 1ns/1ps
module wake_detector #(
  parameter int DOM_MIN = 8,
  parameter int REC_MIN = 8,
  parameter int DEB_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lowpwr_mode,
  input  logic inhibit,
  input  logic clr,
  input  logic bus_dom,
  input  logic wake_pin,
  output logic wake_evt,
  output logic wake_local,
  output logic bias_up
);
  logic [1:0] sync_q;
  logic       armed, remote_hit, local_hit, any_hit;
  logic       evt_q, loc_q;

  assign armed   = lowpwr_mode && !inhibit;
  assign any_hit = remote_hit || local_hit;

  wk_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({bus_dom, wake_pin}), .q(sync_q)
  );

  wk_remote #(.DOM_MIN(DOM_MIN), .REC_MIN(REC_MIN)) u_remote (
    .clk(clk), .rst_n(rst_n), .armed(armed), .dom(sync_q[1]), .hit(remote_hit)
  );

  wk_local #(.DEB_CYC(DEB_CYC)) u_local (
    .clk(clk), .rst_n(rst_n), .armed(armed), .pin(sync_q[0]),
    .level(bias_up), .hit(local_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= 1'b0;
      loc_q <= 1'b0;
    end else begin
      evt_q <= any_hit || (evt_q && !clr);
      loc_q <= local_hit || (loc_q && !clr);
    end
  end

  assign wake_evt   = evt_q;
  assign wake_local = loc_q;

  assert_armed_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_evt) |-> $past(lowpwr_mode && !inhibit))
    else $error("event raised while disarmed");
  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_evt && !clr) |=> wake_evt)
    else $error("event dropped without clear");
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !any_hit) |=> (!wake_evt && !wake_local))
    else $error("clear ignored");
  assert_local_sub_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_local |-> wake_evt)
    else $error("local flag without event");
endmodule

// File: tb/wake_detector_test.sv
`timescale 1ns/1ps
module wake_detector_test;
  localparam int DOM = 8, REC = 8, DEB = 20;
  localparam int WD_CYCLES = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lowpwr = 1'b0, inh = 1'b0, clr = 1'b0, bus = 1'b0, pin = 1'b0;
  logic evt, loc, bias;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  wake_detector #(.DOM_MIN(DOM), .REC_MIN(REC), .DEB_CYC(DEB)) uut (
    .clk(clk), .rst_n(rst_n), .lowpwr_mode(lowpwr), .inhibit(inh), .clr(clr),
    .bus_dom(bus), .wake_pin(pin), .wake_evt(evt), .wake_local(loc), .bias_up(bias)
  );

  // behavioural reference model: run lengths and a count of good phases
  logic b1, b2, p1, p2, lastlvl;
  int run, good, lrun;
  logic m_evt, m_loc, m_bias, hr, hl, arm_m;
  always @(posedge clk) begin
    if (!rst_n) begin
      b1 = 0; b2 = 0; p1 = 0; p2 = 0; lastlvl = 0;
      run = 0; good = 0; lrun = 0; m_evt = 0; m_loc = 0; m_bias = 0;
    end else begin
      arm_m = lowpwr && !inh; hr = 0; hl = 0;
      if (!arm_m) begin run = 0; good = 0; end
      else begin
        if (run > 0 && b2 == lastlvl) run++;
        else begin
          if (run > 0 && lastlvl == (good % 2 == 0))
            good = (run >= (lastlvl ? DOM : REC)) ? good + 1 : 0;
          run = 1;
        end
        lastlvl = b2;
        if (good == 3 && !b2 && run == REC) begin hr = 1; good = 0; end
      end
      if (p2 != m_bias) begin
        lrun++;
        if (lrun == DEB) begin m_bias = p2; lrun = 0; hl = arm_m; end
      end else lrun = 0;
      m_evt = hr || hl || (m_evt && !clr);
      m_loc = hl || (m_loc && !clr);
      b2 = b1; b1 = bus; p2 = p1; p1 = pin;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    chk("R4 model wake_evt", evt, m_evt);
    chk("R5 model wake_local", loc, m_loc);
    chk("R6 model bias_up", bias, m_bias);
  end

  task automatic brun(input logic v, input int n);
    bus = v;
    repeat (n) @(negedge clk);
  endtask
  task automatic prun(input logic v, input int n);
    pin = v;
    repeat (n) @(negedge clk);
  endtask
  task automatic pair(input int d, input int r);
    brun(1'b1, d); brun(1'b0, r);
  endtask
  task automatic do_clear;
    clr = 1'b1; @(negedge clk); clr = 1'b0; @(negedge clk);
  endtask
  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    int hi_cycles;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset wake_evt", evt, 1'b0);
    chk("R8 reset wake_local", loc, 1'b0);
    chk("R8 reset bias_up", bias, 1'b0);
    lowpwr = 1'b1;
    brun(1'b0, 5);

    // R2: two good pairs
    pair(10, 10); pair(10, 12); brun(1'b0, 4);
    chk("R2 remote event", evt, 1'b1);
    chk("R2 remote keeps local low", loc, 1'b0);
    lowpwr = 1'b0; brun(1'b0, 3);
    chk("R1 event kept after leaving low power", evt, 1'b1);
    lowpwr = 1'b1; do_clear();
    chk("R4 clear", evt, 1'b0);

    // R2 boundary at exact minima
    pair(DOM, REC); pair(DOM, REC); brun(1'b0, 4);
    chk("R2 exact minima fire", evt, 1'b1);
    do_clear();

    // R3: short dominant first, then one pair only
    pair(DOM - 1, 10); pair(10, 10); brun(1'b0, 4);
    chk("R3 short dominant restarts", evt, 1'b0);
    pair(10, 10); brun(1'b0, 4);
    chk("R3 pattern completes after restart", evt, 1'b1);
    do_clear();

    // R3: short recessive; following dominant is a new first phase
    brun(1'b1, 10); brun(1'b0, REC - 1); pair(10, 10); brun(1'b0, 4);
    chk("R3 short recessive restarts", evt, 1'b0);
    pair(10, 10); brun(1'b0, 4);
    chk("R3 second pair after short recessive", evt, 1'b1);
    do_clear();

    // R7: inhibit between pairs
    pair(10, 10); inh = 1'b1; brun(1'b0, 5); inh = 1'b0;
    pair(10, 10); brun(1'b0, 4);
    chk("R7 inhibit discards partial pattern", evt, 1'b0);
    pair(10, 10); brun(1'b0, 4);
    chk("R7 pattern after inhibit", evt, 1'b1);
    do_clear();

    // R1: fully blocked patterns
    inh = 1'b1; pair(10, 10); pair(10, 10); brun(1'b0, 4);
    chk("R1 inhibit blocks remote", evt, 1'b0);
    inh = 1'b0; lowpwr = 1'b0; pair(10, 10); pair(10, 10); brun(1'b0, 4);
    chk("R1 normal mode blocks remote", evt, 1'b0);
    lowpwr = 1'b1; brun(1'b0, 4);

    // R5/R6: local rising change
    prun(1'b1, DEB + 6);
    chk("R5 rising pin event", evt, 1'b1);
    chk("R5 rising pin local flag", loc, 1'b1);
    chk("R6 bias pull-up", bias, 1'b1);
    do_clear();
    chk("R4 clear local", loc, 1'b0);
    prun(1'b0, DEB - 2); prun(1'b1, DEB + 6);
    chk("R6 glitch keeps bias", bias, 1'b1);
    chk("R6 glitch no event", evt, 1'b0);

    // R4: clear held through a falling detection, event seen for one cycle
    clr = 1'b1; pin = 1'b0; hi_cycles = 0;
    for (int i = 0; i < DEB + 10; i++) begin
      @(negedge clk);
      if (evt) hi_cycles++;
    end
    clr = 1'b0; @(negedge clk);
    chk("R4 set wins over clear", hi_cycles == 1, 1'b1);
    chk("R6 bias pull-down", bias, 1'b0);

    // R7: pin change while disarmed
    lowpwr = 1'b0; prun(1'b1, DEB + 6);
    chk("R6 bias follows while disarmed", bias, 1'b1);
    chk("R7 no event while disarmed", evt, 1'b0);
    lowpwr = 1'b1; prun(1'b1, DEB + 6);
    chk("R7 no late event after rearm", evt, 1'b0);

    // R5: falling change while armed
    prun(1'b0, DEB + 6);
    chk("R5 falling pin event", evt, 1'b1);
    chk("R5 falling pin local flag", loc, 1'b1);
    summary();
  end
endmodule